// File: doc/BRIEF.md
# Microcontroller Interrupt Controller

This block collects interrupt requests for a small 8-bit microcontroller core. There are four sources: a selectable edge on an external pin, a timer overflow pulse, a change on a subset of port pins, and a conversion-complete pulse from an analog-to-digital converter. Each source has a sticky flag and an enable bit. The flags and enables for the pin, timer and pin-change sources share one status register. The conversion-complete source keeps its flag and its enable in two separate registers. It is also gated by a peripheral enable in the status register.

The core sees a single interrupt request, which is qualified by the global enable, together with a constant vector address of 004h. When the core acknowledges the request, the global enable is cleared in hardware, so a handler is never interrupted again. The return-from-interrupt strobe sets the global enable again. A separate wake output reports any enabled and flagged source whatever the global enable is, so a sleeping core can resume. Software reads and writes the three registers through a simple register port. A strobe marks each software read of the port pins, which is when the pin-change reference is captured.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, the status register (address 0), the peripheral flag register (address 1) and the peripheral enable register (address 2) all read 00h, and irq and wake are 0.
- R2: The status register holds the pin-change flag in bit 0, the external-pin flag in bit 1, the timer flag in bit 2, and their enables in bits 3, 4 and 5. Bit 6 is the peripheral enable and bit 7 is the global enable. A write to address 0 stores all eight bits, and a read of address 0 returns them.
- R3: A one-cycle tmr_ovf pulse sets status bit 2, and an adc_done pulse sets bit 6 of the peripheral flag register. Both take effect on the next clock edge, whatever the enable bits are.
- R4: The external source is port_in bit 2. When ext_rise_sel is 1, a 0-to-1 transition sets status bit 1. When ext_rise_sel is 0, a 1-to-0 transition sets it. A transition in the other direction leaves the flag unchanged.
- R5: port_rd captures port_in bits 0, 1 and 3 as a reference. Whenever any of those bits differs from the reference, status bit 0 is set. Changes on the other port bits do not set it.
- R6: The hardware never clears a flag. Only a register write clears a flag. When a hardware set and a software write of 0 fall on the same edge, the set wins.
- R7: The conversion-complete source makes a request only when its flag (address 1, bit 6), its enable (address 2, bit 6) and the peripheral enable (status bit 6) are all 1.
- R8: irq is 1 exactly when the global enable is 1 and at least one source has both its flag and its enable set. irq_vec always reads 004h.
- R9: irq_ack clears the global enable on the next edge. This takes priority over reti and over a register write in the same cycle.
- R10: reti sets the global enable on the next edge, unless irq_ack is also high. This takes priority over a register write.
- R11: wake is 1 exactly when some source has both its flag and its enable set (including peripheral gating), independent of the global enable.
- R12: In the peripheral registers, only bit 6 is implemented. The other bits, and every bit of address 3, read as 0, and writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 peripheral flags, 2 peripheral enables |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| port_in | input | 8 | Synchronised port pin values |
| port_rd | input | 1 | Software read of the port; latches the pin-change reference |
| ext_rise_sel | input | 1 | External edge select: 1 rising, 0 falling |
| tmr_ovf | input | 1 | Timer overflow pulse |
| adc_done | input | 1 | Conversion-complete pulse |
| irq_ack | input | 1 | Core accepted the interrupt |
| reti | input | 1 | Return-from-interrupt strobe |
| irq | output | 1 | Interrupt request to the core |
| wake | output | 1 | Wake request from sleep |
| irq_vec | output | 10 | Vector address (004h) |

## Verification
Random cycles toggle all port bits, including the bits outside the watched set. They mix writes to every address with source pulses, acknowledges and returns, and this shows up any confusion between the register layout, the source bits and the gating levels. Directed sequences separate rising from falling external edges and a watched pin change from an unwatched one. They also separate a flag set and a software clear on the same edge, and the conversion source with and without the peripheral enable. Further cases separate acknowledge from return when both arrive together, and a return from a write in the same cycle. Wake and irq are compared in every cycle, so a global enable that leaks into wake is exposed.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    RA_STAT = 2'd0,
    RA_PFLG = 2'd1,
    RA_PEN  = 2'd2,
    RA_RSVD = 2'd3
  } reg_addr_e;

  // status register bit positions
  localparam int B_PCF = 0;
  localparam int B_EXF = 1;
  localparam int B_TMF = 2;
  localparam int B_PCE = 3;
  localparam int B_EXE = 4;
  localparam int B_TME = 5;
  localparam int B_PEE = 6;
  localparam int B_GIE = 7;
  // conversion flag / enable position in the peripheral registers
  localparam int B_ADC = 6;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic hit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin;
  end

  always_comb begin
    if (rise_sel) hit = ~prev_q & pin;
    else          hit = prev_q & ~pin;
  end
endmodule

// File: rtl/irq_pin_change.sv
module irq_pin_change #(
  parameter int               W    = 8,
  parameter logic [W-1:0]     MASK = 8'h0B
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] port,
  input  logic         latch,
  output logic         change
);
  logic [W-1:0] diff;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic ref_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ref_q <= 1'b0;
      else if (latch) ref_q <= port[i] & MASK[i];
    end
    assign diff[i] = (port[i] ^ ref_q) & MASK[i];
  end

  assign change = |diff;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int             PORT_W    = 8,
  parameter int             PC_W      = 10,
  parameter logic [PC_W-1:0] VEC_ADDR = 10'h004,
  parameter logic [PORT_W-1:0] PCHG_MASK = 8'h0B,
  parameter int             EXT_BIT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [PORT_W-1:0] port_in,
  input  logic              port_rd,
  input  logic              ext_rise_sel,
  input  logic              tmr_ovf,
  input  logic              adc_done,
  input  logic              irq_ack,
  input  logic              reti,
  output logic              irq,
  output logic              wake,
  output logic [PC_W-1:0]   irq_vec
);
  localparam int NSRC = 4;

  // asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta_q} <= 2'b00;
    else        {rst_sync_n, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  reg_addr_e sel;
  assign sel = reg_addr_e'(reg_addr);

  logic pc_hit, ext_hit;

  irq_pin_change #(.W(PORT_W), .MASK(PCHG_MASK)) u_pchg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .port   (port_in),
    .latch  (port_rd),
    .change (pc_hit)
  );

  irq_edge_det u_ext (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pin      (port_in[EXT_BIT]),
    .rise_sel (ext_rise_sel),
    .hit      (ext_hit)
  );

  logic [REG_W-1:0] ints_q, ints_d;
  logic             adc_flag_q, adc_flag_d;
  logic             adc_en_q, adc_en_d;
  logic             ints_ce, flag_ce, en_ce;

  assign ints_ce = reg_wr | pc_hit | ext_hit | tmr_ovf | irq_ack | reti;
  assign flag_ce = reg_wr | adc_done;
  assign en_ce   = reg_wr;

  // next state
  always_comb begin
    ints_d     = ints_q;
    adc_flag_d = adc_flag_q;
    adc_en_d   = adc_en_q;
    if (reg_wr) begin
      case (sel)
        RA_STAT: ints_d     = reg_wdata;
        RA_PFLG: adc_flag_d = reg_wdata[B_ADC];
        RA_PEN:  adc_en_d   = reg_wdata[B_ADC];
        default: ;
      endcase
    end
    // hardware sets override software clears
    if (pc_hit)   ints_d[B_PCF] = 1'b1;
    if (ext_hit)  ints_d[B_EXF] = 1'b1;
    if (tmr_ovf)  ints_d[B_TMF] = 1'b1;
    if (adc_done) adc_flag_d    = 1'b1;
    // entry/exit control of the global enable
    if (irq_ack)   ints_d[B_GIE] = 1'b0;
    else if (reti) ints_d[B_GIE] = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ints_q     <= '0;
      adc_flag_q <= 1'b0;
      adc_en_q   <= 1'b0;
    end else begin
      if (ints_ce) ints_q     <= ints_d;
      if (flag_ce) adc_flag_q <= adc_flag_d;
      if (en_ce)   adc_en_q   <= adc_en_d;
    end
  end

  // source gating
  logic [NSRC-1:0] src_live;
  assign src_live[0] = ints_q[B_PCF] & ints_q[B_PCE];
  assign src_live[1] = ints_q[B_EXF] & ints_q[B_EXE];
  assign src_live[2] = ints_q[B_TMF] & ints_q[B_TME];
  assign src_live[3] = adc_flag_q & adc_en_q & ints_q[B_PEE];

  assign wake    = |src_live;
  assign irq     = wake & ints_q[B_GIE];
  assign irq_vec = VEC_ADDR;

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (sel)
      RA_STAT: reg_rdata = ints_q;
      RA_PFLG: reg_rdata[B_ADC] = adc_flag_q;
      RA_PEN:  reg_rdata[B_ADC] = adc_en_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       wake,
  input logic       irq_ack,
  input logic       reti,
  input logic       tmr_ovf,
  input logic       adc_done,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       gie,
  input logic       tmr_flag,
  input logic       adc_flag
);
  // R8
  irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie);
  // R11
  irq_implies_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wake);
  // R9
  ack_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !gie);
  // R10
  reti_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !irq_ack) |=> gie);
  // R3
  tmr_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> tmr_flag);
  // R3
  adc_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_done |=> adc_flag);
  // R6
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_flag && !(reg_wr && reg_addr == 2'd0)) |=> tmr_flag);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .irq      (irq),
  .wake     (wake),
  .irq_ack  (irq_ack),
  .reti     (reti),
  .tmr_ovf  (tmr_ovf),
  .adc_done (adc_done),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .gie      (ints_q[7]),
  .tmr_flag (ints_q[2]),
  .adc_flag (adc_flag_q)
);

// File: tb/irq_ctrl_tb.sv
`timescale 1ns/10ps
module irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] port_in;
  logic       port_rd, ext_rise_sel, tmr_ovf, adc_done, irq_ack, reti;
  logic       irq, wake;
  logic [9:0] irq_vec;

  always #2.5 clk = ~clk;

  irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_in(port_in),
    .port_rd(port_rd), .ext_rise_sel(ext_rise_sel), .tmr_ovf(tmr_ovf),
    .adc_done(adc_done), .irq_ack(irq_ack), .reti(reti), .irq(irq),
    .wake(wake), .irq_vec(irq_vec)
  );

  int  errors = 0;
  int  checks = 0;
  bit  done   = 1'b0;

  // reference model state
  logic [7:0] m_ints, m_snap;
  logic       m_pf, m_pe, m_prev;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [1:0] a);
    case (a)
      2'd0:    return m_ints;
      2'd1:    return {1'b0, m_pf, 6'b0};
      2'd2:    return {1'b0, m_pe, 6'b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_wake();
    return (m_ints[0] & m_ints[3]) | (m_ints[1] & m_ints[4]) |
           (m_ints[2] & m_ints[5]) | (m_pf & m_pe & m_ints[6]);
  endfunction

  task automatic compare_all();
    logic [1:0] keep;
    keep = reg_addr;
    chk("R8 irq", irq, exp_wake() & m_ints[7]);
    chk("R11 wake", wake, exp_wake());
    chk("R8 vector", irq_vec, 16'h0004);
    for (int a = 0; a < 4; a++) begin
      reg_addr = a[1:0];
      #0.2;
      chk(a == 0 ? "R2 status" : (a == 3 ? "R12 unused" : "R12 periph"),
          reg_rdata, exp_read(a[1:0]));
    end
    reg_addr = keep;
  endtask

  task automatic idle();
    reg_wr = 0; port_rd = 0; tmr_ovf = 0; adc_done = 0; irq_ack = 0; reti = 0;
  endtask

  // one clock: model advances with the same inputs the design sees
  task automatic step();
    logic [7:0] n_ints, n_snap;
    logic n_pf, n_pe, pc, ex;
    n_ints = m_ints; n_pf = m_pf; n_pe = m_pe;
    if (reg_wr) begin
      if (reg_addr == 2'd0) n_ints = reg_wdata;
      if (reg_addr == 2'd1) n_pf = reg_wdata[6];
      if (reg_addr == 2'd2) n_pe = reg_wdata[6];
    end
    pc = ((port_in ^ m_snap) & 8'h0B) != 8'h00;
    ex = ext_rise_sel ? (!m_prev && port_in[2]) : (m_prev && !port_in[2]);
    if (pc) n_ints[0] = 1'b1;
    if (ex) n_ints[1] = 1'b1;
    if (tmr_ovf) n_ints[2] = 1'b1;
    if (adc_done) n_pf = 1'b1;
    if (irq_ack) n_ints[7] = 1'b0;
    else if (reti) n_ints[7] = 1'b1;
    n_snap = port_rd ? (port_in & 8'h0B) : m_snap;
    @(posedge clk);
    m_prev = port_in[2];
    @(negedge clk);
    m_ints = n_ints; m_pf = n_pf; m_pe = n_pe; m_snap = n_snap;
    compare_all();
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic rd_check(string tag, logic [1:0] a, logic [7:0] exp);
    logic [1:0] keep;
    keep = reg_addr;
    reg_addr = a; #0.2;
    chk(tag, reg_rdata, exp);
    reg_addr = keep;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    rst_n = 0; reg_addr = 0; reg_wdata = 0; port_in = 0; ext_rise_sel = 1;
    m_ints = 0; m_snap = 0; m_pf = 0; m_pe = 0; m_prev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd_check("R1 status", 2'd0, 8'h00);
    rd_check("R1 pflag", 2'd1, 8'h00);
    rd_check("R1 pen", 2'd2, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 wake", wake, 0);

    // R3 timer flag sets with enables off
    tmr_ovf = 1; step(); idle();
    rd_check("R3 timer flag", 2'd0, 8'h04);
    chk("R3 no irq when disabled", irq, 0);
    wr(2'd0, 8'h00); step(); idle();
    adc_done = 1; step(); idle();
    rd_check("R3 adc flag", 2'd1, 8'h40);
    wr(2'd1, 8'h00); step(); idle();

    // R4 rising mode
    ext_rise_sel = 1; port_in = 8'h04; step();
    rd_check("R4 rising edge", 2'd0, 8'h02);
    wr(2'd0, 8'h00); step(); idle();
    port_in = 8'h00; step();
    rd_check("R4 falling ignored in rising mode", 2'd0, 8'h00);
    // R4 falling mode
    port_in = 8'h04; ext_rise_sel = 0; step();
    rd_check("R4 rising ignored in falling mode", 2'd0, 8'h00);
    port_in = 8'h00; step();
    rd_check("R4 falling edge", 2'd0, 8'h02);
    wr(2'd0, 8'h00); step(); idle();

    // R5 pin change
    port_rd = 1; step(); idle();
    port_in = 8'h14; step();
    rd_check("R5 unwatched bits ignored", 2'd0, 8'h00);
    port_in = 8'h1C; step();
    rd_check("R5 bit3 change", 2'd0, 8'h01);
    port_rd = 1; step(); idle();
    wr(2'd0, 8'h00); step(); idle();
    rd_check("R5 cleared after reference read", 2'd0, 8'h00);

    // R6 set beats clear
    tmr_ovf = 1; wr(2'd0, 8'h00); step(); idle();
    rd_check("R6 set wins", 2'd0, 8'h04);
    wr(2'd0, 8'h00); step(); idle();
    rd_check("R6 software clear", 2'd0, 8'h00);

    // R7 peripheral gating
    wr(2'd2, 8'hFF); step(); idle();
    rd_check("R12 pen only bit6", 2'd2, 8'h40);
    wr(2'd0, 8'h80); step(); idle();
    adc_done = 1; step(); idle();
    chk("R7 gated by peripheral enable", irq, 0);
    chk("R7 no wake when gated", wake, 0);
    wr(2'd0, 8'hC0); step(); idle();
    chk("R7 request with all enables", irq, 1);
    wr(2'd3, 8'hFF); step(); idle();
    rd_check("R12 address 3 reads zero", 2'd3, 8'h00);

    // R9 / R10 / R11
    irq_ack = 1; step(); idle();
    rd_check("R9 ack clears global enable", 2'd0, 8'h40);
    chk("R11 wake without global enable", wake, 1);
    chk("R9 irq dropped", irq, 0);
    reti = 1; step(); idle();
    rd_check("R10 return sets global enable", 2'd0, 8'hC0);
    irq_ack = 1; reti = 1; step(); idle();
    rd_check("R9 ack beats return", 2'd0, 8'h40);
    reti = 1; wr(2'd0, 8'h40); step(); idle();
    rd_check("R10 return beats write", 2'd0, 8'hC0);
    wr(2'd1, 8'h00); step(); idle();
    wr(2'd2, 8'h00); step(); idle();
    wr(2'd0, 8'h00); step(); idle();

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      reg_wr    = ($urandom % 6) == 0;
      reg_addr  = 2'($urandom);
      reg_wdata = 8'($urandom);
      if (($urandom % 4) == 0) port_in = port_in ^ 8'($urandom);
      port_rd   = ($urandom % 8) == 0;
      if (($urandom % 64) == 0) ext_rise_sel = ~ext_rise_sel;
      tmr_ovf   = ($urandom % 16) == 0;
      adc_done  = ($urandom % 16) == 0;
      irq_ack   = ($urandom % 12) == 0;
      reti      = ($urandom % 12) == 0;
      step();
    end
    idle();

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule